// File: doc/BRIEF.md
# Exact-Length Fault-Acknowledge Command Detector

This block sits on a byte stream that arrives in packets. Each byte is marked with a valid strobe and a last-of-packet marker. The block looks for one command: a packet of exactly four bytes, 0x40 followed by three 0x00 bytes. The whole packet must be the command. A longer packet that only starts with these bytes is rejected. This matters because ordinary numeric payloads, such as the big-endian double-precision value 2.0, begin with the same four bytes.

A recognised command sets a sticky acknowledge flag. A separate emergency state is latched by an external fault input. A periodic service tick releases it. On each tick, if the acknowledge flag is set, the emergency state clears and the tick consumes the flag. One command therefore releases the emergency state exactly once. No other link or connection condition gates detection.

The command length, byte width and byte pattern are parameters. Byte 0 of the pattern is the first byte on the wire.

Top module: `ack_cmd_detector`

## Requirements
- R1: A packet of exactly four valid beats carrying 0x40, 0x00, 0x00, 0x00 in that order, with the last marker on the fourth beat, sets `ack_pending` at the clock edge that accepts the fourth beat.
- R2: A packet of more than four beats never sets `ack_pending`, even when its first four bytes are 0x40, 0x00, 0x00, 0x00. This holds for any packet length, including sixteen beats.
- R3: A packet of fewer than four beats never sets `ack_pending`.
- R4: A four-beat packet in which any byte differs from the pattern never sets `ack_pending`. A first byte other than 0x40 is one such case.
- R5: Cycles with `in_valid` low are not counted as bytes. A command whose beats are separated by idle cycles is still recognised.
- R6: When `tick` is high while `ack_pending` is set, `emergency` clears and `ack_pending` clears at that edge, unless `fault_in` is also high.
- R7: While `ack_pending` is clear, `emergency` stays set across any number of ticks.
- R8: `fault_in` high at an edge sets `emergency`. This wins over a tick-driven clear in the same cycle. That tick still consumes `ack_pending`.
- R9: `ack_pending` stays set until a tick consumes it.
- R10: An active-low `rst_n` clears the byte count, `ack_pending` and `emergency`. A packet cut short by reset is never completed by the bytes that follow the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Byte value (DATA_W) |
| in_last | input | 1 | Marks the final byte of a packet when `in_valid` is high |
| fault_in | input | 1 | Sets the emergency state |
| tick | input | 1 | Periodic service strobe, one cycle wide |
| ack_pending | output | 1 | Sticky acknowledge flag |
| emergency | output | 1 | Latched emergency state |

## Verification
Every result takes one register stage. `ack_pending` rises one edge after the beat that carries the last marker. `emergency` follows `fault_in` or a consuming `tick` at the same single edge. The bench drives inputs on the falling edge and advances one rising edge per beat. It compares both outputs against a behavioural queue model on every falling edge, so each result is checked in the half cycle after the edge that produces it. Directed checks at the end of each scenario sample at that same falling edge, after the last stimulus has been clocked.

// File: rtl/ackdet_pkg.sv
package ackdet_pkg;
   // Control pair applied to a set/clear latch
   typedef struct packed {
      logic set;
      logic clr;
   } latch_ctl_t;

   // Next value of a latch where set wins over clear
   function automatic logic latch_next(input logic cur, input latch_ctl_t c);
      return c.set | (cur & ~c.clr);
   endfunction
endpackage

// File: rtl/ackdet_len_ctr.sv
module ackdet_len_ctr #(
   parameter int CMD_LEN = 4,
   parameter int CNT_W   = $clog2(CMD_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic             last,
   output logic [CNT_W-1:0] pos
);
   // pos == CMD_LEN means "past the command length"; it saturates there
   localparam logic [CNT_W-1:0] SAT = CNT_W'(CMD_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (beat) begin
         if (last)          pos <= '0;
         else if (pos != SAT) pos <= pos + 1'b1;
      end
   end
endmodule

// File: rtl/ackdet_match.sv
module ackdet_match #(
   parameter int                      DATA_W  = 8,
   parameter int                      CMD_LEN = 4,
   parameter int                      CNT_W   = $clog2(CMD_LEN + 1),
   parameter logic [CMD_LEN*DATA_W-1:0] PATTERN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat,
   input  logic              last,
   input  logic [DATA_W-1:0] data,
   input  logic [CNT_W-1:0]  pos,
   output logic              hit
);
   localparam int PW = CMD_LEN * DATA_W;

   logic [CMD_LEN-1:0] eq;
   logic               eq_sel;
   logic               run;
   logic               prefix_ok;

   // One comparator per command position
   for (genvar i = 0; i < CMD_LEN; i++) begin : g_cmp
      assign eq[i] = (data == PATTERN[PW-1-i*DATA_W -: DATA_W]);
   end

   always_comb begin
      eq_sel = 1'b0;
      for (int k = 0; k < CMD_LEN; k++)
         if (pos == CNT_W'(k)) eq_sel = eq[k];
   end

   // First byte starts a fresh run; later bytes extend the previous one
   assign run = eq_sel & ((pos == '0) | prefix_ok);
   assign hit = beat & last & run & (pos == CNT_W'(CMD_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prefix_ok <= 1'b0;
      else if (beat) prefix_ok <= last ? 1'b0 : run;
   end
endmodule

// File: rtl/ackdet_state.sv
module ackdet_state
   import ackdet_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic tick,
   input  logic fault_in,
   output logic ack_pending,
   output logic emergency
);
   latch_ctl_t ack_ctl, emg_ctl;
   logic       consume;

   assign consume     = tick & ack_pending;
   assign ack_ctl.set = hit;
   assign ack_ctl.clr = tick;
   assign emg_ctl.set = fault_in;
   assign emg_ctl.clr = consume;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_pending <= 1'b0;
         emergency   <= 1'b0;
      end else begin
         ack_pending <= latch_next(ack_pending, ack_ctl);
         emergency   <= latch_next(emergency, emg_ctl);
      end
   end
endmodule

// File: rtl/ack_cmd_detector.sv
module ack_cmd_detector #(
   parameter int                      DATA_W  = 8,
   parameter int                      CMD_LEN = 4,
   parameter logic [CMD_LEN*DATA_W-1:0] PATTERN = 32'h4000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   input  logic              fault_in,
   input  logic              tick,
   output logic              ack_pending,
   output logic              emergency
);
   localparam int CNT_W = $clog2(CMD_LEN + 1);

   if (CMD_LEN < 1) begin : g_bad_len
      $error("CMD_LEN must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be at least 1");
   end

   logic [CNT_W-1:0] pos;
   logic             hit;

   ackdet_len_ctr #(.CMD_LEN(CMD_LEN), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .beat(in_valid), .last(in_last), .pos(pos)
   );

   ackdet_match #(.DATA_W(DATA_W), .CMD_LEN(CMD_LEN), .CNT_W(CNT_W),
                  .PATTERN(PATTERN)) u_match (
      .clk(clk), .rst_n(rst_n), .beat(in_valid), .last(in_last),
      .data(in_data), .pos(pos), .hit(hit)
   );

   ackdet_state u_state (
      .clk(clk), .rst_n(rst_n), .hit(hit), .tick(tick), .fault_in(fault_in),
      .ack_pending(ack_pending), .emergency(emergency)
   );
endmodule

// File: rtl/ackdet_chk.sv
module ackdet_chk #(
   parameter int CMD_LEN = 4
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_last,
   input logic fault_in,
   input logic tick,
   input logic ack_pending,
   input logic emergency
);
   // Independent beat count of the current packet, saturating
   localparam int BW = $clog2(CMD_LEN + 2);
   logic [BW-1:0] beats;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beats <= '0;
      else if (in_valid) begin
         if (in_last)                        beats <= '0;
         else if (beats != BW'(CMD_LEN + 1)) beats <= beats + 1'b1;
      end
   end

   // R2 R3
   wrong_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && beats != BW'(CMD_LEN - 1) && !ack_pending)
      |=> !ack_pending);

   // R1
   rise_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_pending && !(in_valid && in_last)) |=> !ack_pending);

   // R6
   clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ack_pending && !fault_in) |=> !emergency);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emergency && !(tick && ack_pending)) |=> emergency);

   // R8
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in |=> emergency);

   // R9
   ack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pending && !tick) |=> ack_pending);
endmodule

bind ack_cmd_detector ackdet_chk #(.CMD_LEN(CMD_LEN)) u_ackdet_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .fault_in(fault_in), .tick(tick), .ack_pending(ack_pending),
   .emergency(emergency)
);

// File: tb/test_ack_cmd_detector.sv
`timescale 1ns/1ps
module test_ack_cmd_detector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_last = 1'b0;
   logic       fault_in = 1'b0;
   logic       tick = 1'b0;
   logic       ack_pending, emergency;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cycles  = 0;
   string cur_req = "R10";

   always #2 clk = ~clk;   // 250 MHz

   ack_cmd_detector i_ack_cmd_detector (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .fault_in(fault_in), .tick(tick),
      .ack_pending(ack_pending), .emergency(emergency)
   );

   // Behavioural reference model
   logic [7:0] pkt_q[$];
   int m_ack = 0;
   int m_emg = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_q.delete();
         m_ack = 0;
         m_emg = 0;
      end else begin
         int hit;
         int used;
         hit = 0;
         if (in_valid) begin
            pkt_q.push_back(in_data);
            if (in_last) begin
               if (pkt_q.size() == 4)
                  hit = (pkt_q[0] == 8'h40 && pkt_q[1] == 8'h00 &&
                         pkt_q[2] == 8'h00 && pkt_q[3] == 8'h00) ? 1 : 0;
               pkt_q.delete();
            end
         end
         used  = (tick && m_ack != 0) ? 1 : 0;
         m_emg = fault_in ? 1 : (used != 0 ? 0 : m_emg);
         m_ack = hit != 0 ? 1 : (tick ? 0 : m_ack);
      end
   end

   // Per-clock comparison
   always @(negedge clk) begin
      if (rst_n) begin
         n_tests++;
         if (ack_pending !== 1'(m_ack) || emergency !== 1'(m_emg)) begin
            n_fail++;
            $display("FAIL %s cycle %0d: ack=%b emg=%b expected ack=%0d emg=%0d",
                     cur_req, cycles, ack_pending, emergency, m_ack, m_emg);
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic exp_ack, input logic exp_emg);
      n_tests++;
      if (ack_pending !== exp_ack || emergency !== exp_emg) begin
         n_fail++;
         $display("FAIL %s: ack=%b emg=%b expected ack=%b emg=%b",
                  req, ack_pending, emergency, exp_ack, exp_emg);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0; in_last = 1'b0; fault_in = 1'b0; tick = 1'b0;
         @(negedge clk);
      end
   endtask

   // Bytes left-justified in d: byte i = d[127-8*i -: 8]
   task automatic send(input logic [127:0] d, input int len, input int gap);
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_data  = d[127-8*i -: 8];
         in_last  = (i == len - 1);
         @(negedge clk);
         in_valid = 1'b0; in_last = 1'b0;
         if (gap > 0 && i != len - 1) idle(gap);
      end
   endtask

   task automatic pulse_tick(input logic with_fault);
      tick = 1'b1; fault_in = with_fault;
      @(negedge clk);
      tick = 1'b0; fault_in = 1'b0;
   endtask

   localparam logic [127:0] CMD = {32'h4000_0000, 96'h0};

   initial begin
      @(negedge clk); @(negedge clk);
      cur_req = "R10";
      check("R10 reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      idle(1);
      check("R10 after release", 1'b0, 1'b0);

      cur_req = "R8";
      fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
      check("R8 fault sets", 1'b0, 1'b1);

      cur_req = "R7";
      for (int k = 0; k < 5; k++) begin
         pulse_tick(1'b0);
         idle(3);
      end
      check("R7 held without ack", 1'b0, 1'b1);

      cur_req = "R3";
      send({24'h40_0000, 104'h0}, 3, 0); idle(1);
      send({8'h40, 120'h0}, 1, 0); idle(1);
      check("R3 short packets", 1'b0, 1'b1);

      cur_req = "R2";
      send({64'h4000_0000_0000_0000, 64'h0}, 8, 0); idle(1);
      send(CMD, 5, 0); idle(1);
      send(CMD, 16, 0); idle(1);
      check("R2 long packets", 1'b0, 1'b1);

      cur_req = "R4";
      send({32'h4100_0000, 96'h0}, 4, 0); idle(1);
      send({32'h4000_0100, 96'h0}, 4, 0); idle(1);
      send({32'h0000_0040, 96'h0}, 4, 0); idle(1);
      check("R4 wrong content", 1'b0, 1'b1);

      cur_req = "R5";
      send(CMD, 4, 2);
      check("R5 R1 command with gaps", 1'b1, 1'b1);

      cur_req = "R9";
      idle(10);
      check("R9 ack sticky", 1'b1, 1'b1);

      cur_req = "R6";
      pulse_tick(1'b0);
      check("R6 tick clears", 1'b0, 1'b0);

      fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
      pulse_tick(1'b0);
      check("R6 one release per command", 1'b0, 1'b1);

      cur_req = "R1";
      send(CMD, 4, 0);
      check("R1 back-to-back command", 1'b1, 1'b1);

      cur_req = "R8";
      pulse_tick(1'b1);
      check("R8 fault wins, ack consumed", 1'b0, 1'b1);

      cur_req = "R1";
      send(CMD, 4, 0);
      send(CMD, 4, 0);
      pulse_tick(1'b0);
      check("R1 R6 repeated command", 1'b0, 1'b0);

      cur_req = "R10";
      fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
      send({16'h4000, 112'h0}, 2, 0);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      check("R10 reset clears", 1'b0, 1'b0);
      send({16'h0000, 112'h0}, 2, 0);
      idle(1);
      check("R10 cut packet not completed", 1'b0, 1'b0);

      idle(2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule